// File: doc/BRIEF.md
# FSK Delay-Line Discriminator Receiver

This block turns a stream of signed 9-bit line samples, arriving at the sample rate (nominally 13.6 kHz), into line-state decisions for a four-state FSK link. The four states are silence, a 900 Hz end-of-message tone, a 1200 Hz mark and a 2200 Hz space. Each accepted sample first passes through a smooth automatic level control. A running estimate of the mean rectified amplitude divides the sample, so the signal reaches a fixed scale without the harmonics that a hard limiter would add.

The normalized sample is multiplied by the normalized sample from two sample periods earlier. At 13.6 kHz that lag is about 147 µs, which is a quarter period at the 1700 Hz centre. The product therefore averages to a level proportional to cos(2π·f·2/13600): positive for the mark and end-of-message tones, negative for the space tone. A single-pole low-pass filter smooths the product. Two thresholds then produce the data bit and the end-of-message flag. When the level estimate is too small, the block reports silence.

Samples enter through a valid/ready handshake. The block takes one sample at a time and holds `s_ready` low while a sample is in progress. A source that keeps `s_valid` high during that time is stalled, and whatever it presents then is not consumed. The source must keep `s_data` steady from the cycle it raises `s_valid` until the handshake completes. The three decision outputs are plain level signals.

Top module: `fsk_disc_rx`

## Requirements
- R1: `s_ready` is high in reset and when idle. A sample is taken at a clock edge where `s_valid` and `s_ready` are both high. `s_ready` then stays low until it rises 24 clock edges after the accepting edge (NW+2, with NW = 22). Data presented while `s_ready` is low is ignored.
- R2: The level estimate L (15 bits, reset 0) is updated on each accepted sample x as L ← L + floor((64·|x| − L) / 32), using an arithmetic shift.
- R3: The normalized value is q = floor(|x|·8192 / L), computed with the updated L and saturated at 255. v takes the sign of x, so −256 maps through |x| = 256.
- R4: The discriminator product for sample n is p[n] = v[n]·v[n−2]. The two delay registers reset to 0.
- R5: The filter level F (reset 0) is updated as F ← F + floor((p − F) / 8), using an arithmetic shift.
- R6: When the sample is not silent, `tone_valid` = 1 and `data_bit` = 1 (mark) if F ≥ 0, or 0 (space) if F < 0.
- R7: When the sample is not silent, `eom_flag` = 1 exactly when F > 11300. At a normalized full-scale tone this is about 0.56 of the product scale.
- R8: A sample is silent when its updated L < 512. For a silent sample, v = 0 is fed to the delay line and filter, `tone_valid` = 0, `eom_flag` = 0, and `data_bit` keeps its previous value.
- R9: All three outputs reset to 0. They change only at the edge where `s_ready` rises, which is one clock after F is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Sample offered |
| s_ready | output | 1 | Block can take a sample |
| s_data | input | 9 | Signed line sample |
| data_bit | output | 1 | 1 = mark, 0 = space |
| tone_valid | output | 1 | A tone is present (not silence) |
| eom_flag | output | 1 | End-of-message tone detected |

## Verification
Each result is due 24 clock edges after the accepting edge. The level estimate is written at the accepting edge, the divider runs for 22 steps, the filter is written at the next edge, and the decision outputs at the one after that. The bench counts edges from acceptance until it sees `s_ready` high on a falling edge, and requires that count to be 24. It compares the three outputs with a bit-exact arithmetic model only at that falling edge. Halfway through each busy window it also confirms that the outputs still hold the previous sample's decisions.

// File: rtl/fsk_rx_pkg.sv
package fsk_rx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DIV  = 2'd1,
    ST_OUT  = 2'd2
  } rx_state_t;
endpackage

// File: rtl/fsk_level_ctl.sv
// Rectified-amplitude tracker: single-pole IIR on |x| with a silence flag.
module fsk_level_ctl #(
  parameter int AW      = 9,
  parameter int FB      = 6,
  parameter int LS      = 5,
  parameter int MIN_LVL = 512
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 upd,
  input  logic [AW-1:0]        mag,
  output logic [AW+FB-1:0]     lvl_next,
  output logic                 quiet
);
  localparam int LVW = AW + FB;

  logic [LVW-1:0]        lvl;
  logic [LVW-1:0]        tgt;
  logic signed [LVW+1:0] diff;

  assign tgt      = LVW'(mag) << FB;
  assign diff     = $signed({2'b00, tgt}) - $signed({2'b00, lvl});
  assign lvl_next = lvl + LVW'(diff >>> LS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl   <= '0;
      quiet <= 1'b1;
    end else if (upd) begin
      lvl   <= lvl_next;
      quiet <= (lvl_next < LVW'(MIN_LVL));
    end
  end
endmodule

// File: rtl/fsk_seq_div.sv
// Restoring divider, one quotient bit per clock, NW steps after start.
module fsk_seq_div #(
  parameter int NW  = 22,
  parameter int DVW = 15
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [NW-1:0]  dividend,
  input  logic [DVW-1:0] divisor,
  output logic [NW-1:0]  quot,
  output logic           done
);
  localparam int CW = $clog2(NW + 1);

  logic [NW-1:0]  dvd;
  logic [DVW-1:0] dsr;
  logic [DVW:0]   rem;
  logic [DVW:0]   rem_sh;
  logic [DVW:0]   rem_nx;
  logic           ge;
  logic [CW-1:0]  cnt;

  always_comb begin
    rem_sh = {rem[DVW-1:0], dvd[NW-1]};
    ge     = (rem_sh >= {1'b0, dsr});
    rem_nx = ge ? (rem_sh - {1'b0, dsr}) : rem_sh;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dvd  <= '0;
      dsr  <= '0;
      rem  <= '0;
      quot <= '0;
      cnt  <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        dvd  <= dividend;
        dsr  <= divisor;
        rem  <= '0;
        quot <= '0;
        cnt  <= CW'(NW);
      end else if (cnt != '0) begin
        dvd  <= dvd << 1;
        rem  <= rem_nx;
        quot <= {quot[NW-2:0], ge};
        cnt  <= cnt - 1'b1;
        if (cnt == CW'(1)) done <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/fsk_disc_core.sv
// Delay-and-multiply discriminator followed by a single-pole low-pass.
module fsk_disc_core #(
  parameter int XW  = 9,
  parameter int DLY = 2,
  parameter int FW  = 20,
  parameter int LPS = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 upd,
  input  logic signed [XW-1:0] v,
  output logic signed [FW-1:0] lvl_f
);
  localparam int PW = 2 * XW;

  logic signed [XW-1:0] tap [DLY];
  logic signed [PW-1:0] prod;
  logic signed [FW:0]   diff;

  assign prod = v * tap[DLY-1];
  assign diff = $signed({{(FW+1-PW){prod[PW-1]}}, prod}) - $signed({lvl_f[FW-1], lvl_f});

  generate
    for (genvar i = 0; i < DLY; i++) begin : g_tap
      always_ff @(posedge clk) begin
        if (!rst_n)   tap[i] <= '0;
        else if (upd) tap[i] <= (i == 0) ? v : tap[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n)   lvl_f <= '0;
    else if (upd) lvl_f <= lvl_f + FW'(diff >>> LPS);
  end
endmodule

// File: rtl/fsk_disc_rx.sv
module fsk_disc_rx
  import fsk_rx_pkg::*;
#(
  parameter int XW      = 9,
  parameter int LVL_FB  = 6,
  parameter int LVL_SH  = 5,
  parameter int MIN_LVL = 512,
  parameter int NORM_FB = 7,
  parameter int DLY     = 2,
  parameter int LPF_SH  = 3,
  parameter int EOM_THR = 11300
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          s_valid,
  output logic          s_ready,
  input  logic [XW-1:0] s_data,
  output logic          data_bit,
  output logic          tone_valid,
  output logic          eom_flag
);
  localparam int LVW  = XW + LVL_FB;
  localparam int NW   = XW + NORM_FB + LVL_FB;
  localparam int FW   = 2 * XW + 2;
  localparam int NMAX = (1 << (XW - 1)) - 1;

  rx_state_t            state;
  logic                 acc;
  logic [XW-1:0]        mag;
  logic [LVW-1:0]       lvl_next;
  logic                 quiet;
  logic                 neg_r;
  logic [NW-1:0]        quot;
  logic                 div_done;
  logic [XW-2:0]        qsat;
  logic signed [XW-1:0] norm;
  logic                 core_upd;
  logic signed [FW-1:0] lvl_f;

  assign s_ready  = (state == ST_IDLE);
  assign acc      = s_valid && s_ready;
  assign mag      = s_data[XW-1] ? XW'(~s_data + 1'b1) : s_data;
  assign core_upd = (state == ST_DIV) && div_done;

  always_comb begin
    qsat = (quot > NW'(NMAX)) ? (XW-1)'(NMAX) : quot[XW-2:0];
    if (quiet)      norm = '0;
    else if (neg_r) norm = -$signed({1'b0, qsat});
    else            norm =  $signed({1'b0, qsat});
  end

  fsk_level_ctl #(
    .AW(XW), .FB(LVL_FB), .LS(LVL_SH), .MIN_LVL(MIN_LVL)
  ) u_lvl (
    .clk(clk), .rst_n(rst_n), .upd(acc), .mag(mag),
    .lvl_next(lvl_next), .quiet(quiet)
  );

  fsk_seq_div #(.NW(NW), .DVW(LVW)) u_div (
    .clk(clk), .rst_n(rst_n), .start(acc),
    .dividend({mag, {(NORM_FB + LVL_FB){1'b0}}}),
    .divisor(lvl_next), .quot(quot), .done(div_done)
  );

  fsk_disc_core #(.XW(XW), .DLY(DLY), .FW(FW), .LPS(LPF_SH)) u_core (
    .clk(clk), .rst_n(rst_n), .upd(core_upd), .v(norm), .lvl_f(lvl_f)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      neg_r      <= 1'b0;
      data_bit   <= 1'b0;
      tone_valid <= 1'b0;
      eom_flag   <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (acc) begin
          neg_r <= s_data[XW-1];
          state <= ST_DIV;
        end
        ST_DIV: if (div_done) state <= ST_OUT;
        ST_OUT: begin
          if (quiet) begin
            tone_valid <= 1'b0;
            eom_flag   <= 1'b0;
          end else begin
            tone_valid <= 1'b1;
            data_bit   <= ~lvl_f[FW-1];
            eom_flag   <= (lvl_f > FW'(EOM_THR));
          end
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fsk_disc_rx_chk.sv
module fsk_disc_rx_chk (
  input logic clk,
  input logic rst_n,
  input logic s_valid,
  input logic s_ready,
  input logic data_bit,
  input logic tone_valid,
  input logic eom_flag
);
  AST_ACCEPT_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready) |=> !s_ready); // R1

  AST_EOM_IS_MARK: assert property (@(posedge clk) disable iff (!rst_n)
    eom_flag |-> data_bit); // R7

  AST_EOM_NEEDS_TONE: assert property (@(posedge clk) disable iff (!rst_n)
    eom_flag |-> tone_valid); // R8

  AST_SILENCE_HOLDS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    !tone_valid |-> $stable(data_bit)); // R8

  AST_OUT_MOVES_WITH_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({data_bit, tone_valid, eom_flag}) |-> $rose(s_ready)); // R9
endmodule

bind fsk_disc_rx fsk_disc_rx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
  .data_bit(data_bit), .tone_valid(tone_valid), .eom_flag(eom_flag)
);

// File: tb/fsk_disc_rx_test.sv
module fsk_disc_rx_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       s_valid = 1'b0;
  logic       s_ready;
  logic [8:0] s_data = '0;
  logic       data_bit, tone_valid, eom_flag;

  int nchk = 0;
  int nerr = 0;
  bit fin = 1'b0;

  int m_lvl = 0, m_d1 = 0, m_d2 = 0, m_f = 0;
  bit m_data = 0, m_valid = 0, m_eom = 0;

  always #5 clk = ~clk;

  fsk_disc_rx uut (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .s_data(s_data), .data_bit(data_bit), .tone_valid(tone_valid),
    .eom_flag(eom_flag)
  );

  task automatic chk(string tag, int act, int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Arithmetic model taken from the requirements
  task automatic model(int x);
    int ax, q, v, p;
    bit quiet;
    ax = (x < 0) ? -x : x;
    m_lvl = m_lvl + (((ax * 64) - m_lvl) >>> 5);          // R2
    quiet = (m_lvl < 512);                                // R8
    if (quiet) v = 0;
    else begin
      q = (ax * 8192) / m_lvl;                            // R3
      if (q > 255) q = 255;
      v = (x < 0) ? -q : q;
    end
    p = v * m_d2;                                         // R4
    m_d2 = m_d1;
    m_d1 = v;
    m_f = m_f + ((p - m_f) >>> 3);                        // R5
    if (quiet) begin
      m_valid = 0;
      m_eom = 0;
    end else begin
      m_valid = 1;
      m_data = (m_f >= 0);                                // R6
      m_eom = (m_f > 11300);                              // R7
    end
  endtask

  function automatic int tone(real amp, real f, int n);
    real r;
    int v;
    r = amp * $sin(2.0 * 3.14159265358979 * f * n / 13600.0);
    v = $rtoi(r + ((r >= 0.0) ? 0.5 : -0.5));
    if (v > 255) v = 255;
    if (v < -256) v = -256;
    return v;
  endfunction

  // Called on a falling edge with s_ready high
  task automatic send(int x, bit stall);
    int n;
    logic [2:0] prev;
    prev = {data_bit, tone_valid, eom_flag};
    s_data = x[8:0];
    s_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    if (stall) s_data = 9'h0AA ^ x[8:0];
    else s_valid = 1'b0;
    model(x);
    n = 0;
    while (!s_ready) begin
      @(posedge clk);
      @(negedge clk);
      n++;
      if (n == 12) chk("R9 outputs held mid-busy", int'({data_bit, tone_valid, eom_flag}), int'(prev));
    end
    chk("R1 edges until ready", n, 24);
    chk("R8 tone_valid", int'(tone_valid), int'(m_valid));
    chk("R6 data_bit (via R2 R3 R4 R5)", int'(data_bit), int'(m_data));
    chk("R7 eom_flag", int'(eom_flag), int'(m_eom));
  endtask

  task automatic stop_valid();
    s_valid = 1'b0;
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R9 reset data_bit", int'(data_bit), 0);
    chk("R9 reset tone_valid", int'(tone_valid), 0);
    chk("R9 reset eom_flag", int'(eom_flag), 0);
    chk("R1 ready in reset", int'(s_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready idle", int'(s_ready), 1);

    for (int i = 0; i < 40; i++) send(0, 1'b0);                       // R8 silence
    for (int i = 0; i < 150; i++) send(tone(200.0, 1200.0, i), 1'b0); // R6 mark
    for (int i = 0; i < 150; i++) send(tone(200.0, 2200.0, i), 1'b1); // R6 space, R1 stall
    stop_valid();
    for (int i = 0; i < 150; i++) send(tone(200.0, 900.0, i), 1'b0);  // R7 end of message
    for (int i = 0; i < 120; i++) send(0, 1'b1);                       // R8 decay to silence
    stop_valid();
    for (int i = 0; i < 60; i++) send(((i % 4) < 2) ? 255 : -256, 1'b0); // R3 saturation
    for (int a = 1; a <= 5; a++)
      for (int i = 0; i < 20; i++) send(tone(4.0 * a, 1700.0, i), 1'b0); // R8 threshold
    for (int i = 0; i < 30; i++) send(tone(255.0, 1200.0, i), 1'b0);
    for (int i = 0; i < 30; i++) send(-100, 1'b0);                     // R5 DC input

    fin = 1'b1;
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!fin) begin
      nchk++;
      nerr++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  end
endmodule